// File: doc/BRIEF.md
# UART Interrupt Identifier

This block sits between the event logic of a UART and its host bus. It takes four interrupt conditions: a receiver line error, receive data ready, transmit holding register empty and a modem status change. A 4-bit enable register picks which of them may raise a single active-high interrupt line. A readable identification byte reports whether any source is active and, if so, which active source has the highest priority.

Each source has a pending latch. The latch is set when its condition rises and cleared by the bus access that services it: reading the line status, the receive buffer or the modem status, or writing the holding register. Reading the identification byte also clears a transmit-empty event, but only when that event is the one being reported. Host software either takes interrupts or writes zero to the enable register and polls.

Top module: `uart_irq_ident`

## Requirements
- R1: A synchronous active-high reset clears the enable register, every pending latch and the edge history. After reset the interrupt output is 0, the identification byte reads 8'h01 and the enable readback reads 8'h00.
- R2: An enable write stores the 4-bit write data. The readback byte returns those bits in positions 3:0 and 0 in bits 7:4. The mapping is: bit 0 receive data ready, bit 1 transmit holding empty, bit 2 line status error, bit 3 modem status.
- R3: A source is active only while its pending latch is set, its condition input is 1 and its enable bit is 1. The interrupt output is 1 exactly when at least one source is active.
- R4: Identification bit 0 is 0 when any source is active and 1 otherwise. Bits 7:3 always read 0.
- R5: Identification bits 2:1 give the code of the highest-priority active source. Line status error is 11 (highest), then receive data ready 10, then transmit holding empty 01, then modem status 00 (lowest). With no active source the byte is 8'h01.
- R6: A pending latch is set one cycle after a cycle in which its condition is 1 and was 0 in the previous cycle, counting the cycle after reset as preceded by 0. A new rising edge sets the latch again after it has been cleared. A set in the same cycle as a clear strobe wins.
- R7: A line status read strobe clears the line status latch, and a receive buffer read strobe clears the receive data latch, at the next clock edge.
- R8: A holding register write strobe clears the transmit-empty latch. An identification read strobe clears it only when the byte being read reports code 01 with bit 0 equal to 0. An identification read that reports any other source leaves the transmit-empty latch set.
- R9: A modem status read strobe clears the modem status latch at the next clock edge.
- R10: With all enable bits 0, the interrupt output is 0 and the identification byte is 8'h01 whatever the latches hold. Pending latches are kept, so enabling again restores the report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high master reset |
| cond_line_err | input | 1 | Receiver line error condition |
| cond_rx_ready | input | 1 | Receive data ready condition |
| cond_thr_empty | input | 1 | Transmit holding register empty condition |
| cond_modem_chg | input | 1 | Modem status change condition |
| ier_wr_en | input | 1 | Enable register write strobe |
| ier_wdata | input | 4 | Enable register write data |
| ier_rdata | output | 8 | Enable register readback |
| rd_ident | input | 1 | Identification byte read strobe |
| rd_line_stat | input | 1 | Line status register read strobe |
| rd_rx_buf | input | 1 | Receive buffer read strobe |
| rd_modem_stat | input | 1 | Modem status register read strobe |
| wr_tx_hold | input | 1 | Holding register write strobe |
| irq | output | 1 | Active-high interrupt output |
| ident_rdata | output | 8 | Identification byte |

## Verification
Directed sequences stack all four sources one at a time. The expected code must then step through the priority order. Each service strobe is applied while a lower source is still waiting, which separates a correct clear from a clear of the wrong latch. Identification reads are issued once while the transmit-empty event is reported and once while a higher source masks it, which tells the conditional clear apart from an unconditional one. A random phase with a fixed seed then toggles conditions, strobes and enable writes together, including a rising edge in the same cycle as its own clear. A bench model compares the interrupt line, the identification byte and the enable readback in every cycle.

// File: rtl/uirq_pkg.sv
package uirq_pkg;

    localparam int NUM_SRC = 4;
    localparam int BYTE_W  = 8;

    // Source positions, fixed by the enable bit assignment
    localparam int IDX_RXRDY = 0;
    localparam int IDX_THR   = 1;
    localparam int IDX_LINE  = 2;
    localparam int IDX_MODEM = 3;

    typedef enum logic [1:0] {
        CODE_MODEM = 2'b00,
        CODE_THR   = 2'b01,
        CODE_RXRDY = 2'b10,
        CODE_LINE  = 2'b11
    } irq_code_e;

    typedef struct packed {
        irq_code_e code;
        logic      none;
    } ident_t;

    localparam int IDENT_W = $bits(ident_t);

    // Fixed four-level priority: line > rx ready > thr empty > modem
    function automatic ident_t pick_highest(input logic [NUM_SRC-1:0] act);
        ident_t id;
        id.none = ~|act;
        if (act[IDX_LINE])       id.code = CODE_LINE;
        else if (act[IDX_RXRDY]) id.code = CODE_RXRDY;
        else if (act[IDX_THR])   id.code = CODE_THR;
        else                     id.code = CODE_MODEM;
        return id;
    endfunction

    function automatic logic [BYTE_W-1:0] pack_ident(input ident_t id);
        return {{(BYTE_W-IDENT_W){1'b0}}, id};
    endfunction

endpackage

// File: rtl/uirq_enable_reg.sv
module uirq_enable_reg
    import uirq_pkg::*;
#(
    parameter int EN_W   = NUM_SRC,
    parameter int READ_W = BYTE_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [EN_W-1:0]   wdata,
    output logic [EN_W-1:0]   enables,
    output logic [READ_W-1:0] rdata
);
    localparam int PAD_W = READ_W - EN_W;

    logic [EN_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= wdata;
    end

    assign enables = en_q;
    assign rdata   = {{PAD_W{1'b0}}, en_q};

    assert_ier_store_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> (rdata == {{PAD_W{1'b0}}, $past(wdata)}));

endmodule

// File: rtl/uirq_src_latch.sv
module uirq_src_latch (
    input  logic clk,
    input  logic rst,
    input  logic cond,
    input  logic clr,
    output logic pending
);
    logic prev_q;
    logic pend_q;
    logic rise;

    assign rise = cond & ~prev_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            prev_q <= cond;
            pend_q <= (pend_q & ~clr) | rise;
        end
    end

    assign pending = pend_q;

    assert_set_on_rise_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(cond) |=> pending);

    // Same rule serves the clears of R7, R8 and R9
    assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !rise) |=> !pending);

endmodule

// File: rtl/uirq_prio_enc.sv
module uirq_prio_enc
    import uirq_pkg::*;
(
    input  logic [NUM_SRC-1:0] active,
    output ident_t             ident,
    output logic [BYTE_W-1:0]  ident_byte
);
    always_comb begin
        ident      = pick_highest(active);
        ident_byte = pack_ident(ident);
    end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
    import uirq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cond_line_err,
    input  logic              cond_rx_ready,
    input  logic              cond_thr_empty,
    input  logic              cond_modem_chg,
    input  logic              ier_wr_en,
    input  logic [NUM_SRC-1:0] ier_wdata,
    output logic [BYTE_W-1:0] ier_rdata,
    input  logic              rd_ident,
    input  logic              rd_line_stat,
    input  logic              rd_rx_buf,
    input  logic              rd_modem_stat,
    input  logic              wr_tx_hold,
    output logic              irq,
    output logic [BYTE_W-1:0] ident_rdata
);
    logic [NUM_SRC-1:0] cond_vec;
    logic [NUM_SRC-1:0] clr_vec;
    logic [NUM_SRC-1:0] pend_vec;
    logic [NUM_SRC-1:0] en_vec;
    logic [NUM_SRC-1:0] act_vec;
    ident_t             ident;
    logic               thr_reported;

    always_comb begin
        cond_vec            = '0;
        cond_vec[IDX_RXRDY] = cond_rx_ready;
        cond_vec[IDX_THR]   = cond_thr_empty;
        cond_vec[IDX_LINE]  = cond_line_err;
        cond_vec[IDX_MODEM] = cond_modem_chg;
    end

    uirq_enable_reg #(.EN_W(NUM_SRC), .READ_W(BYTE_W)) u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ier_wr_en),
        .wdata   (ier_wdata),
        .enables (en_vec),
        .rdata   (ier_rdata)
    );

    assign thr_reported = ~ident.none & (ident.code == CODE_THR);

    always_comb begin
        clr_vec            = '0;
        clr_vec[IDX_RXRDY] = rd_rx_buf;
        clr_vec[IDX_THR]   = wr_tx_hold | (rd_ident & thr_reported);
        clr_vec[IDX_LINE]  = rd_line_stat;
        clr_vec[IDX_MODEM] = rd_modem_stat;
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
        uirq_src_latch u_latch (
            .clk     (clk),
            .rst     (rst),
            .cond    (cond_vec[g]),
            .clr     (clr_vec[g]),
            .pending (pend_vec[g])
        );
    end

    assign act_vec = pend_vec & cond_vec & en_vec;
    assign irq     = |act_vec;

    uirq_prio_enc u_enc (
        .active     (act_vec),
        .ident      (ident),
        .ident_byte (ident_rdata)
    );

    assert_ident_flag_R4: assert property (@(posedge clk) disable iff (rst)
        (ident_rdata[0] == !irq) && (ident_rdata[7:3] == 5'd0));

    assert_line_top_R5: assert property (@(posedge clk) disable iff (rst)
        (irq && cond_line_err && pend_vec[IDX_LINE] && en_vec[IDX_LINE])
            |-> (ident_rdata[2:0] == 3'b110));

    assert_ident_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_ident && ident_rdata[2:0] == 3'b010 && !$rose(cond_thr_empty))
            |=> (ident_rdata[2:0] != 3'b010));

    assert_polled_R10: assert property (@(posedge clk) disable iff (rst)
        (ier_rdata == 8'h00) |-> (!irq && ident_rdata == 8'h01));

endmodule

// File: tb/uart_irq_ident_tb_top.sv
`timescale 1ns/1ps
module uart_irq_ident_tb_top;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cond_line_err = 0, cond_rx_ready = 0, cond_thr_empty = 0, cond_modem_chg = 0;
    logic ier_wr_en = 0;
    logic [3:0] ier_wdata = 0;
    logic rd_ident = 0, rd_line_stat = 0, rd_rx_buf = 0, rd_modem_stat = 0, wr_tx_hold = 0;
    logic [7:0] ier_rdata, ident_rdata;
    logic irq;

    int checks = 0;
    int fails  = 0;

    // Bench model state: index 0 rx, 1 thr, 2 line, 3 modem
    logic [3:0] m_pend = 0, m_prev = 0, m_ier = 0;

    always #10 clk = ~clk;

    uart_irq_ident dut_i (
        .clk(clk), .rst(rst),
        .cond_line_err(cond_line_err), .cond_rx_ready(cond_rx_ready),
        .cond_thr_empty(cond_thr_empty), .cond_modem_chg(cond_modem_chg),
        .ier_wr_en(ier_wr_en), .ier_wdata(ier_wdata), .ier_rdata(ier_rdata),
        .rd_ident(rd_ident), .rd_line_stat(rd_line_stat), .rd_rx_buf(rd_rx_buf),
        .rd_modem_stat(rd_modem_stat), .wr_tx_hold(wr_tx_hold),
        .irq(irq), .ident_rdata(ident_rdata)
    );

    function automatic logic [3:0] m_cond();
        return {cond_modem_chg, cond_line_err, cond_thr_empty, cond_rx_ready};
    endfunction

    function automatic logic [7:0] m_ident();
        logic [3:0] a;
        a = m_pend & m_cond() & m_ier;
        if (a[2])      return 8'h06;
        else if (a[0]) return 8'h04;
        else if (a[1]) return 8'h02;
        else if (a[3]) return 8'h00;
        else           return 8'h01;
    endfunction

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model, take one clock edge, update the model
    task automatic tick();
        logic [3:0] rise, clr;
        #1;
        if (!rst) begin
            chk({7'd0, irq}, {7'd0, |(m_pend & m_cond() & m_ier)}, "R3 irq");
            chk(ident_rdata, m_ident(), "R5 R4 ident byte");
            chk(ier_rdata, {4'd0, m_ier}, "R2 enable readback");
        end
        @(posedge clk);
        if (rst) begin
            m_pend = 0; m_prev = 0; m_ier = 0;
        end else begin
            rise = m_cond() & ~m_prev;
            clr  = {rd_modem_stat, rd_line_stat,
                    wr_tx_hold | (rd_ident && m_ident() == 8'h02), rd_rx_buf};
            m_pend = (m_pend & ~clr) | rise;
            m_prev = m_cond();
            if (ier_wr_en) m_ier = ier_wdata;
        end
        @(negedge clk);
        rd_ident = 0; rd_line_stat = 0; rd_rx_buf = 0; rd_modem_stat = 0;
        wr_tx_hold = 0; ier_wr_en = 0;
    endtask

    task automatic set_ier(input logic [3:0] v);
        ier_wr_en = 1; ier_wdata = v; tick();
    endtask

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'd20240611);
        @(negedge clk);
        tick(); tick();
        rst = 0;
        #1;
        chk({7'd0, irq}, 8'h00, "R1 irq after reset");
        chk(ident_rdata, 8'h01, "R1 ident after reset");
        chk(ier_rdata, 8'h00, "R1 enable after reset");

        set_ier(4'hF);
        chk(ier_rdata, 8'h0F, "R2 upper bits zero");

        cond_thr_empty = 1; tick();
        chk(ident_rdata, 8'h02, "R6 thr set on rise");
        chk({7'd0, irq}, 8'h01, "R3 irq high");
        cond_rx_ready = 1; tick();
        chk(ident_rdata, 8'h04, "R5 rx over thr");
        cond_line_err = 1; tick();
        chk(ident_rdata, 8'h06, "R5 line highest");
        cond_modem_chg = 1; tick();
        chk(ident_rdata, 8'h06, "R5 modem lowest");

        rd_line_stat = 1; tick();
        chk(ident_rdata, 8'h04, "R7 line cleared");
        rd_rx_buf = 1; tick();
        chk(ident_rdata, 8'h02, "R7 rx cleared");
        rd_ident = 1; tick();
        chk(ident_rdata, 8'h00, "R8 thr cleared by ident read");
        rd_modem_stat = 1; tick();
        chk(ident_rdata, 8'h01, "R9 modem cleared");
        chk({7'd0, irq}, 8'h00, "R9 irq low");

        cond_thr_empty = 0; tick();
        cond_thr_empty = 1; tick();
        chk(ident_rdata, 8'h02, "R6 thr rearmed");
        cond_line_err = 0; tick();
        cond_line_err = 1; tick();
        chk(ident_rdata, 8'h06, "R5 line rearmed");
        rd_ident = 1; tick();
        chk(ident_rdata, 8'h06, "R8 ident read of line code");
        rd_line_stat = 1; tick();
        chk(ident_rdata, 8'h02, "R8 thr kept when masked");
        wr_tx_hold = 1; tick();
        chk(ident_rdata, 8'h01, "R8 thr cleared by write");

        cond_rx_ready = 0; tick();
        cond_rx_ready = 1; tick();
        chk(ident_rdata, 8'h04, "R6 rx rearmed");
        set_ier(4'h0);
        chk({7'd0, irq}, 8'h00, "R10 polled irq low");
        chk(ident_rdata, 8'h01, "R10 polled ident");
        set_ier(4'hF);
        chk(ident_rdata, 8'h04, "R10 pending kept");

        cond_rx_ready = 0; tick();
        chk(ident_rdata, 8'h01, "R3 condition gates source");
        rd_rx_buf = 1; tick();

        set_ier(4'b0010);
        cond_thr_empty = 0; cond_rx_ready = 0; tick();
        cond_thr_empty = 1; cond_rx_ready = 1; tick();
        chk(ident_rdata, 8'h02, "R3 disabled rx ignored");
        set_ier(4'hF);
        wr_tx_hold = 1; rd_rx_buf = 1; cond_modem_chg = 0; tick();
        cond_modem_chg = 1; rd_modem_stat = 1; tick();
        chk(ident_rdata, 8'h00, "R6 set wins over clear");

        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 6 == 0) begin
                case ($urandom % 4)
                    0: cond_rx_ready  = ~cond_rx_ready;
                    1: cond_thr_empty = ~cond_thr_empty;
                    2: cond_line_err  = ~cond_line_err;
                    default: cond_modem_chg = ~cond_modem_chg;
                endcase
            end
            rd_ident      = ($urandom % 5 == 0);
            rd_line_stat  = ($urandom % 7 == 0);
            rd_rx_buf     = ($urandom % 7 == 0);
            rd_modem_stat = ($urandom % 7 == 0);
            wr_tx_hold    = ($urandom % 7 == 0);
            if ($urandom % 25 == 0) begin
                ier_wr_en = 1;
                ier_wdata = 4'($urandom);
            end
            rst = ($urandom % 700 == 0);
            tick();
        end
        rst = 0;
        tick();

        summary();
        $finish;
    end

endmodule